// File: doc/BRIEF.md
# DRAM access cycle sequencer

This block times one read or write to a DRAM that is used without page mode, on an external bus. A requester presents a direction flag, a two-bit byte-lane mask, a row address, a column address and (for writes) write data. Once the sequencer takes the request, it walks a fixed chain of bus states. First comes one precharge cycle and then one row cycle. Next come zero to three row-hold cycles, then two column cycles. It then reports completion with a one-cycle done pulse.

The row-hold cycles keep the row address on the multiplexed address pins after the row strobe has fallen. This gives a slow part enough row-address hold time before the column address replaces it. The number of hold cycles comes from a two-bit configuration input that is sampled when the request is taken. Read data is captured from the data pins at the end of the second column cycle and is held on a result port.

Only one access is in flight at a time. `req_ready` is high only while the sequencer is idle, so a request presented during an access is simply not taken.

Top module: `dram_cycle_seq`

## Requirements
- R1: `req_ready` is 1 only while idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `bs_n` is 0 for exactly the first cycle after that edge (precharge), and in that cycle `ras_n`, both CAS strobes, `we_n` and `oe_n` are 1.
- R2: A taken access occupies, in order: precharge, row, H row-hold cycles, column-1 and column-2, which is 4+H cycles. These are followed by a single done cycle.
- R3: H equals the value of `cfg_hold` (0 to 3) on the edge that takes the request. Changing `cfg_hold` during an access has no effect on that access.
- R4: `ras_n` is 0 from the row cycle through column-2 and is 1 in every other cycle.
- R5: `mem_addr` carries the row address, zero-extended, during precharge, row and every row-hold cycle, without change. It carries the column address, zero-extended, during column-1 and column-2. It is 0 while idle.
- R6: `cas_hi_n` is 0 only in column-2 and only when mask bit 1 is set. `cas_lo_n` is 0 only in column-2 and only when mask bit 0 is set. A mask of 00 keeps both high.
- R7: For a write (`req_write`=1), `we_n` is 0 and `dq_oe` is 1 during column-1 and column-2, with `dq_out` equal to the captured write data. `oe_n` stays 1.
- R8: For a read, `oe_n` is 0 during column-1 and column-2, and `we_n` stays 1 and `dq_oe` stays 0. `rd_data` takes the value of `dq_in` sampled at the end of column-2. It holds that value until the next read finishes, and writes leave it unchanged.
- R9: `done` is 1 for exactly the one cycle after column-2. In that cycle every strobe is 1 and `req_ready` is 1.
- R10: A request presented while `req_ready` is 0 is not taken. It does not change the running access, and it starts no access if it is withdrawn before the sequencer is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_lanes | input | 2 | Byte-lane mask, bit 1 upper, bit 0 lower |
| req_row | input | ROW_W | Row address |
| req_col | input | COL_W | Column address |
| req_wdata | input | DATA_W | Write data |
| cfg_hold | input | 2 | Number of row-hold cycles |
| mem_addr | output | max(ROW_W,COL_W) | Multiplexed DRAM address |
| ras_n | output | 1 | Row strobe, active low |
| cas_hi_n | output | 1 | Upper-lane column strobe, active low |
| cas_lo_n | output | 1 | Lower-lane column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| oe_n | output | 1 | Output enable, active low |
| bs_n | output | 1 | Bus-start strobe, active low |
| dq_out | output | DATA_W | Write data to the data pins |
| dq_oe | output | 1 | Drive enable for the data pins |
| dq_in | input | DATA_W | Read data from the data pins |
| done | output | 1 | Access complete pulse |
| rd_data | output | DATA_W | Captured read data |

## Verification
A miscounted row-hold counter changes the position of the column address and of the `we_n`/`oe_n` edge by whole cycles. Because the bench predicts every pin in every cycle of the access, this appears within the same access. A wrong phase decode breaks the fixed ordering of `bs_n`, `ras_n` and CAS, and the checker's ordering properties catch it on the very edge where it happens. A bad read-capture point or a stale lane mask appears at `rd_data` or the CAS pins in the done cycle or in column-2. Busy-time requests carry different field values, so any leak of those values into the running access changes the address or strobes in the following cycles.

// File: rtl/dseq_pkg.sv
package dseq_pkg;

    // Bus phase of one DRAM access
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_PRE  = 3'd1,
        PH_ROW  = 3'd2,
        PH_HOLD = 3'd3,
        PH_COL1 = 3'd4,
        PH_COL2 = 3'd5
    } phase_t;

    localparam int LANE_N = 2;  // upper and lower byte lane

endpackage

// File: rtl/dseq_ctrl.sv
module dseq_ctrl
    import dseq_pkg::*;
#(
    parameter int ROW_W  = 12,
    parameter int COL_W  = 10,
    parameter int DATA_W = 16,
    parameter int HOLD_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    input  logic              req_write_i,
    input  logic [LANE_N-1:0] req_lanes_i,
    input  logic [ROW_W-1:0]  req_row_i,
    input  logic [COL_W-1:0]  req_col_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    input  logic [HOLD_W-1:0] cfg_hold_i,
    input  logic [DATA_W-1:0] dq_in_i,
    output phase_t            phase_o,
    output logic              ready_o,
    output logic              write_o,
    output logic [LANE_N-1:0] lanes_o,
    output logic [ROW_W-1:0]  row_o,
    output logic [COL_W-1:0]  col_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic              done_o,
    output logic [DATA_W-1:0] rdata_o
);

    typedef struct packed {
        phase_t              phase;
        logic [HOLD_W-1:0]   cnt;
        logic                wr;
        logic [LANE_N-1:0]   lanes;
        logic [ROW_W-1:0]    row;
        logic [COL_W-1:0]    col;
        logic [DATA_W-1:0]   wdata;
        logic                done;
        logic [DATA_W-1:0]   rdata;
    } seq_s;

    seq_s s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        case (s_q.phase)
            PH_IDLE: begin
                if (req_valid_i) begin
                    s_d.phase = PH_PRE;
                    s_d.cnt   = cfg_hold_i;
                    s_d.wr    = req_write_i;
                    s_d.lanes = req_lanes_i;
                    s_d.row   = req_row_i;
                    s_d.col   = req_col_i;
                    s_d.wdata = req_wdata_i;
                end
            end
            PH_PRE: begin
                s_d.phase = PH_ROW;
            end
            PH_ROW: begin
                if (s_q.cnt == '0) begin
                    s_d.phase = PH_COL1;
                end else begin
                    s_d.phase = PH_HOLD;
                    s_d.cnt   = s_q.cnt - HOLD_W'(1);
                end
            end
            PH_HOLD: begin
                if (s_q.cnt == '0) begin
                    s_d.phase = PH_COL1;
                end else begin
                    s_d.cnt = s_q.cnt - HOLD_W'(1);
                end
            end
            PH_COL1: begin
                s_d.phase = PH_COL2;
            end
            PH_COL2: begin
                s_d.phase = PH_IDLE;
                s_d.done  = 1'b1;
                if (!s_q.wr) begin
                    s_d.rdata = dq_in_i;
                end
            end
            default: begin
                s_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign phase_o = s_q.phase;
    assign ready_o = (s_q.phase == PH_IDLE);
    assign write_o = s_q.wr;
    assign lanes_o = s_q.lanes;
    assign row_o   = s_q.row;
    assign col_o   = s_q.col;
    assign wdata_o = s_q.wdata;
    assign done_o  = s_q.done;
    assign rdata_o = s_q.rdata;

endmodule

// File: rtl/dseq_pins.sv
module dseq_pins
    import dseq_pkg::*;
#(
    parameter int ROW_W  = 12,
    parameter int COL_W  = 10,
    parameter int DATA_W = 16,
    parameter int AW     = 12
) (
    input  phase_t            phase_i,
    input  logic              write_i,
    input  logic [LANE_N-1:0] lanes_i,
    input  logic [ROW_W-1:0]  row_i,
    input  logic [COL_W-1:0]  col_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [AW-1:0]     addr_o,
    output logic              ras_n_o,
    output logic [LANE_N-1:0] cas_n_o,
    output logic              we_n_o,
    output logic              oe_n_o,
    output logic              bs_n_o,
    output logic              dq_oe_o,
    output logic [DATA_W-1:0] dq_out_o
);

    logic col_phase;

    always_comb begin
        addr_o    = '0;
        ras_n_o   = 1'b1;
        bs_n_o    = 1'b1;
        col_phase = 1'b0;
        case (phase_i)
            PH_PRE: begin
                addr_o = AW'(row_i);
                bs_n_o = 1'b0;
            end
            PH_ROW, PH_HOLD: begin
                addr_o  = AW'(row_i);
                ras_n_o = 1'b0;
            end
            PH_COL1, PH_COL2: begin
                addr_o    = AW'(col_i);
                ras_n_o   = 1'b0;
                col_phase = 1'b1;
            end
            default: begin
                addr_o = '0;
            end
        endcase
    end

    assign we_n_o   = !(col_phase && write_i);
    assign oe_n_o   = !(col_phase && !write_i);
    assign dq_oe_o  = col_phase && write_i;
    assign dq_out_o = wdata_i;

    // one column strobe per byte lane
    for (genvar g = 0; g < LANE_N; g++) begin : g_cas
        assign cas_n_o[g] = !((phase_i == PH_COL2) && lanes_i[g]);
    end

endmodule

// File: rtl/dram_cycle_seq.sv
module dram_cycle_seq
    import dseq_pkg::*;
#(
    parameter int ROW_W  = 12,
    parameter int COL_W  = 10,
    parameter int DATA_W = 16,
    parameter int HOLD_W = 2
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    req_valid,
    output logic                                    req_ready,
    input  logic                                    req_write,
    input  logic [1:0]                              req_lanes,
    input  logic [ROW_W-1:0]                        req_row,
    input  logic [COL_W-1:0]                        req_col,
    input  logic [DATA_W-1:0]                       req_wdata,
    input  logic [HOLD_W-1:0]                       cfg_hold,
    output logic [((ROW_W>COL_W)?ROW_W:COL_W)-1:0]  mem_addr,
    output logic                                    ras_n,
    output logic                                    cas_hi_n,
    output logic                                    cas_lo_n,
    output logic                                    we_n,
    output logic                                    oe_n,
    output logic                                    bs_n,
    output logic [DATA_W-1:0]                       dq_out,
    output logic                                    dq_oe,
    input  logic [DATA_W-1:0]                       dq_in,
    output logic                                    done,
    output logic [DATA_W-1:0]                       rd_data
);

    localparam int AW = (ROW_W > COL_W) ? ROW_W : COL_W;

    phase_t            phase;
    logic              lat_wr;
    logic [LANE_N-1:0] lat_lanes;
    logic [ROW_W-1:0]  lat_row;
    logic [COL_W-1:0]  lat_col;
    logic [DATA_W-1:0] lat_wdata;
    logic [LANE_N-1:0] cas_n;

    dseq_ctrl #(
        .ROW_W  (ROW_W),
        .COL_W  (COL_W),
        .DATA_W (DATA_W),
        .HOLD_W (HOLD_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid_i (req_valid),
        .req_write_i (req_write),
        .req_lanes_i (req_lanes),
        .req_row_i   (req_row),
        .req_col_i   (req_col),
        .req_wdata_i (req_wdata),
        .cfg_hold_i  (cfg_hold),
        .dq_in_i     (dq_in),
        .phase_o     (phase),
        .ready_o     (req_ready),
        .write_o     (lat_wr),
        .lanes_o     (lat_lanes),
        .row_o       (lat_row),
        .col_o       (lat_col),
        .wdata_o     (lat_wdata),
        .done_o      (done),
        .rdata_o     (rd_data)
    );

    dseq_pins #(
        .ROW_W  (ROW_W),
        .COL_W  (COL_W),
        .DATA_W (DATA_W),
        .AW     (AW)
    ) u_pins (
        .phase_i  (phase),
        .write_i  (lat_wr),
        .lanes_i  (lat_lanes),
        .row_i    (lat_row),
        .col_i    (lat_col),
        .wdata_i  (lat_wdata),
        .addr_o   (mem_addr),
        .ras_n_o  (ras_n),
        .cas_n_o  (cas_n),
        .we_n_o   (we_n),
        .oe_n_o   (oe_n),
        .bs_n_o   (bs_n),
        .dq_oe_o  (dq_oe),
        .dq_out_o (dq_out)
    );

    assign cas_hi_n = cas_n[1];
    assign cas_lo_n = cas_n[0];

endmodule

// File: rtl/dseq_chk.sv
module dseq_chk #(
    parameter int AW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_ready,
    input logic [AW-1:0] mem_addr,
    input logic          ras_n,
    input logic          cas_hi_n,
    input logic          cas_lo_n,
    input logic          we_n,
    input logic          oe_n,
    input logic          bs_n,
    input logic          dq_oe,
    input logic          done
);

    // R1
    bs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bs_n |-> (!req_ready && ras_n && cas_hi_n && cas_lo_n && we_n && oe_n));

    // R2
    row_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bs_n |=> !ras_n);

    // R4
    ras_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> $past(!bs_n));

    // R9
    ras_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> done);

    // R5
    row_hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n && $past(!ras_n) && we_n && oe_n) |-> $stable(mem_addr));

    // R6
    cas_in_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cas_hi_n || !cas_lo_n) |-> !ras_n);

    // R7
    wr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (!we_n && oe_n));

    // R8
    oe_we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !oe_n));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

bind dram_cycle_seq dseq_chk #(.AW(AW)) u_dseq_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .mem_addr  (mem_addr),
    .ras_n     (ras_n),
    .cas_hi_n  (cas_hi_n),
    .cas_lo_n  (cas_lo_n),
    .we_n      (we_n),
    .oe_n      (oe_n),
    .bs_n      (bs_n),
    .dq_oe     (dq_oe),
    .done      (done)
);

// File: tb/test_dram_cycle_seq.sv
module test_dram_cycle_seq;

    localparam int ROW_W  = 12;
    localparam int COL_W  = 10;
    localparam int DATA_W = 16;
    localparam int AW     = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_write = 1'b0;
    logic [1:0]        req_lanes = '0;
    logic [ROW_W-1:0]  req_row = '0;
    logic [COL_W-1:0]  req_col = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic [1:0]        cfg_hold = '0;
    logic [AW-1:0]     mem_addr;
    logic              ras_n, cas_hi_n, cas_lo_n, we_n, oe_n, bs_n, dq_oe, done;
    logic [DATA_W-1:0] dq_out;
    logic [DATA_W-1:0] dq_in = '0;
    logic [DATA_W-1:0] rd_data;

    int errors = 0;
    int checks = 0;
    bit finished = 0;
    logic [DATA_W-1:0] exp_rd = '0;

    always #2 clk = ~clk;

    dram_cycle_seq i_dram_cycle_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_lanes(req_lanes), .req_row(req_row),
        .req_col(req_col), .req_wdata(req_wdata), .cfg_hold(cfg_hold),
        .mem_addr(mem_addr), .ras_n(ras_n), .cas_hi_n(cas_hi_n),
        .cas_lo_n(cas_lo_n), .we_n(we_n), .oe_n(oe_n), .bs_n(bs_n),
        .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in), .done(done),
        .rd_data(rd_data)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // expected pin values for cycle k after acceptance, hold count h
    function automatic logic [7:0] exp_strobes(input int k, input int h,
                                               input logic wr, input logic [1:0] ln);
        logic col, ras, bs, we, oe, oe_d, chi, clo, dn;
        col  = (k == 2 + h) || (k == 3 + h);
        ras  = !(k >= 1 && k <= 3 + h);
        bs   = !(k == 0);
        we   = !(col && wr);
        oe   = !(col && !wr);
        oe_d = col && wr;
        chi  = !((k == 3 + h) && ln[1]);
        clo  = !((k == 3 + h) && ln[0]);
        dn   = (k == 4 + h);
        return {dn, oe_d, bs, oe, we, clo, chi, ras};
    endfunction

    function automatic logic [AW-1:0] exp_addr(input int k, input int h,
                                               input logic [ROW_W-1:0] r,
                                               input logic [COL_W-1:0] c);
        if (k <= 1 + h) return AW'(r);
        if (k <= 3 + h) return AW'(c);
        return '0;
    endfunction

    task automatic access(input logic wr, input logic [1:0] ln, input logic [ROW_W-1:0] r,
                          input logic [COL_W-1:0] c, input logic [DATA_W-1:0] wd,
                          input int h);
        logic [DATA_W-1:0] rdv;
        rdv = DATA_W'($urandom());
        // present request at a negedge while idle
        chk(32'(req_ready), 32'd1, "R1 ready before request");
        req_valid = 1'b1; req_write = wr; req_lanes = ln; req_row = r;
        req_col = c; req_wdata = wd; cfg_hold = 2'(h);
        for (int k = 0; k <= 4 + h; k++) begin
            @(negedge clk);
            chk(32'({done, dq_oe, bs_n, oe_n, we_n, cas_lo_n, cas_hi_n, ras_n}),
                32'(exp_strobes(k, h, wr, ln)),
                $sformatf("R2/R4/R6/R7/R8/R9 strobes k=%0d h=%0d wr=%0d", k, h, wr));
            chk(32'(mem_addr), 32'(exp_addr(k, h, r, c)),
                $sformatf("R5 address k=%0d h=%0d", k, h));
            chk(32'(req_ready), 32'(k == 4 + h), $sformatf("R1 ready k=%0d", k));
            if (wr && (k == 2 + h || k == 3 + h))
                chk(32'(dq_out), 32'(wd), "R7 write data");
            if (k == 0) begin
                // R3 R10: busy-time request with other fields and new hold
                req_write = !wr; req_lanes = ~ln; req_row = ~r; req_col = ~c;
                cfg_hold = 2'(3 - h);
            end
            if (k == 3 + h) begin
                dq_in = rdv;
                req_valid = 1'b0;
            end
            if (k == 4 + h) begin
                dq_in = ~rdv;
                if (!wr) exp_rd = rdv;
                chk(32'(rd_data), 32'(exp_rd), "R8 read data capture/hold");
            end
        end
        @(negedge clk);
        chk(32'({bs_n, ras_n, done, req_ready}), 32'hF - 32'd2,
            "R10 withdrawn busy request started nothing");
        chk(32'(mem_addr), 32'd0, "R5 idle address");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd8817));
        repeat (3) @(negedge clk);
        // reset state
        chk(32'({done, dq_oe, bs_n, oe_n, we_n, cas_lo_n, cas_hi_n, ras_n}), 32'h3F,
            "R1 reset strobes");
        chk(32'(req_ready), 32'd1, "R1 reset ready");
        chk(32'(rd_data), 32'd0, "R8 reset read data");
        chk(32'(mem_addr), 32'd0, "R5 reset address");
        rst_n = 1'b1;
        @(negedge clk);
        // directed: every hold count, both directions, edge lane masks (R3, R6)
        for (int h = 0; h < 4; h++) begin
            access(1'b0, 2'b11, 12'hFFF, 10'h3FF, 16'h0000, h);
            access(1'b1, 2'b00, 12'h000, 10'h001, 16'hA5C3, h);
        end
        access(1'b0, 2'b10, 12'h5A5, 10'h2AA, 16'h0, 3);
        access(1'b1, 2'b01, 12'h123, 10'h0F0, 16'hFFFF, 0);
        // random mix
        for (int n = 0; n < 60; n++) begin
            access(1'($urandom()), 2'($urandom()), ROW_W'($urandom()),
                   COL_W'($urandom()), DATA_W'($urandom()), int'($urandom() % 4));
        end
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule